// File: doc/BRIEF.md
# Nine-bit SPI frame packer

This block prepares display transactions for a three-wire serial link that has no separate data/control pin. A transaction is one 8-bit command followed by any number of 8-bit data bytes. Each input byte is widened to a 9-bit word whose leading bit tells the display whether the payload is a command (0) or data (1). These words are packed back to back, most significant bit first, into a stream of bytes that a byte-wide serial shifter can transmit.

A byte-oriented shifter can only send whole bytes, and the display consumes whole 9-bit words. Each frame is therefore closed with zero bits up to the next multiple of 72 bits, which is the least common multiple of 8 and 9. Input and output are valid/ready streams. The input carries a start-of-frame mark and a last mark. The output marks the final padding byte of each frame. A separate combinational port gives the packed byte count for a frame with a given number of data bytes, so software or a DMA engine can size the transfer before it starts.

Top module: `ninebit_frame_packer`

## Requirements
- R1: Each accepted byte becomes a 9-bit word. The flag bit is sent first, then payload bits 7 down to 0. The flag is 0 for a command byte and 1 for a data byte.
- R2: The command word of a frame starts at bit 7 of the frame's first output byte. That byte equals the command shifted right by one. The next byte carries the command's bit 0 in its bit 7.
- R3: Words are packed with no gaps across byte boundaries. Eight words fill exactly nine output bytes, and word k of a group puts its flag in bit 7−k of byte k of that group.
- R4: A frame with N data bytes produces exactly ((N+8)/8)·9 output bytes (integer division). Every bit after the last real word is zero.
- R5: `outLast` is 1 on the final byte of each frame and 0 on every other output byte.
- R6: `lenBytes` combinationally equals ((`lenN`+8)/8)·9.
- R7: An input byte is flagged as a command when `inFirst` is 1, or when no frame is open (after reset or after a frame's last output byte). Otherwise it is flagged as data.
- R8: Once a byte with `inLast` is accepted, `inReady` stays 0 until the frame's final output byte has been transferred.
- R9: While `outValid` is 1 and `outReady` is 0, `outValid` and `outData` hold their values into the next cycle.
- R10: A synchronous reset (`rst` high at a clock edge) empties the packer: `outValid` goes to 0, `inReady` goes to 1, and the next byte starts a new frame as a command even if a frame was open.
- R11: The bit accumulator never overflows. A word is taken in only while at most ACC_W−9 bits are held, and a word is never pushed in the same cycle that a byte is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Packer can take an input byte |
| inData | input | 8 | Input byte (command or data) |
| inFirst | input | 1 | Byte is the command that opens a frame |
| inLast | input | 1 | Byte is the final byte of its frame |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Shifter takes the output byte |
| outData | output | 8 | Packed output byte |
| outLast | output | 1 | Final (padding-closed) byte of the frame |
| lenN | input | LEN_W | Data byte count for size query |
| lenBytes | output | LEN_W+4 | Packed byte count for lenN data bytes |

## Verification
Some properties are checked on every clock cycle. The accumulator must never overflow, and a push and a pop must never fall in the same cycle. A stalled output byte must hold steady. Input readiness must drop after a last byte, and `outLast` must only appear on a valid byte. Other behaviours can only be shown by the bench's scenarios: the exact bit placement of flags and payloads, the zero padding to a 72-bit boundary, the per-frame byte counts, command flagging without a start mark, and recovery from a reset in the middle of a frame. The bench shows them by comparing whole frames against a bit-level model while the output is throttled.

// File: rtl/packer_pkg.sv
package packer_pkg;
  localparam int PK_BYTE_W  = 8;
  localparam int PK_WORD_W  = PK_BYTE_W + 1;
  localparam int PK_GROUP   = 8;   // words per 72-bit group

  typedef struct packed {
    logic                 push;  // load one 9-bit word into the accumulator
    logic                 pop;   // shift one byte out of the accumulator
    logic [PK_WORD_W-1:0] word;  // word to load (flag in MSB)
  } pk_strobe_t;
endpackage

// File: rtl/packer_len.sv
module packer_len #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] lenN,
  output logic [LEN_W+3:0] lenBytes
);
  localparam int GRP_W = LEN_W + 1;

  logic [GRP_W-1:0] groups;

  // one command word plus N data words, rounded up to groups of eight words
  always_comb begin
    groups   = (GRP_W'(lenN) + GRP_W'(8)) >> 3;
    lenBytes = ((LEN_W+4)'(groups) << 3) + (LEN_W+4)'(groups);
  end
endmodule

// File: rtl/packer_dp.sv
module packer_dp
  import packer_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int FILL_W = $clog2(ACC_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pk_strobe_t           strobe,
  output logic [FILL_W-1:0]    fill,
  output logic                 outValid,
  output logic [PK_BYTE_W-1:0] outData
);
  localparam int PAD_W = ACC_W - PK_WORD_W;

  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      fill <= '0;
    end else if (strobe.push) begin
      acc  <= acc | ({strobe.word, {PAD_W{1'b0}}} >> fill);
      fill <= fill + FILL_W'(PK_WORD_W);
    end else if (strobe.pop) begin
      acc  <= acc << PK_BYTE_W;
      fill <= fill - FILL_W'(PK_BYTE_W);
    end
  end

  assign outValid = (fill >= FILL_W'(PK_BYTE_W));
  assign outData  = acc[ACC_W-1 -: PK_BYTE_W];

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    strobe.push |-> (fill <= FILL_W'(PAD_W)));

  assert_no_push_pop_R11: assert property (@(posedge clk) disable iff (rst)
    !(strobe.push && strobe.pop));

  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (rst)
    (outValid && !strobe.pop) |=> (outValid && $stable(outData)));
endmodule

// File: rtl/packer_ctrl.sv
module packer_ctrl
  import packer_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int FILL_W = $clog2(ACC_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [PK_BYTE_W-1:0] inData,
  input  logic                 inFirst,
  input  logic                 inLast,
  input  logic                 outReady,
  input  logic [FILL_W-1:0]    fill,
  output logic                 inReady,
  output logic                 outLast,
  output pk_strobe_t           strobe
);
  localparam int CNT_W = $clog2(PK_GROUP);

  logic             inFrame;
  logic             padding;
  logic [CNT_W-1:0] wordCnt;
  logic             canPush;
  logic             isCmd;
  logic             accept;
  logic             padPush;
  logic             byteOut;

  always_comb begin
    canPush = (fill <= FILL_W'(ACC_W - PK_WORD_W));
    isCmd   = inFirst || !inFrame;
    inReady = canPush && !padding;
    accept  = inValid && inReady;
    padPush = padding && canPush && (wordCnt != '0);
    byteOut = (fill >= FILL_W'(PK_BYTE_W)) && outReady;
    outLast = padding && (wordCnt == '0) && (fill == FILL_W'(PK_BYTE_W));

    strobe.push = accept || padPush;
    strobe.pop  = byteOut;
    strobe.word = padPush ? '0 : {~isCmd, inData};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inFrame <= 1'b0;
      padding <= 1'b0;
      wordCnt <= '0;
    end else begin
      if (accept) begin
        wordCnt <= isCmd ? CNT_W'(1) : wordCnt + CNT_W'(1);
        inFrame <= 1'b1;
        if (inLast) padding <= 1'b1;
      end else if (padPush) begin
        wordCnt <= wordCnt + CNT_W'(1);
      end
      if (byteOut && outLast) begin
        padding <= 1'b0;
        inFrame <= 1'b0;
      end
    end
  end

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && inLast) |=> !inReady);

  assert_last_valid_R5: assert property (@(posedge clk) disable iff (rst)
    outLast |-> (fill >= FILL_W'(PK_BYTE_W)));

  assert_frame_closes_R7: assert property (@(posedge clk) disable iff (rst)
    (byteOut && outLast) |=> (!inFrame && inReady));
endmodule

// File: rtl/ninebit_frame_packer.sv
module ninebit_frame_packer
  import packer_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic [7:0]       inData,
  input  logic             inFirst,
  input  logic             inLast,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outData,
  output logic             outLast,
  input  logic [LEN_W-1:0] lenN,
  output logic [LEN_W+3:0] lenBytes
);
  localparam int FILL_W = $clog2(ACC_W + 1);

  pk_strobe_t        strobe;
  logic [FILL_W-1:0] fill;

  packer_ctrl #(.ACC_W(ACC_W), .FILL_W(FILL_W)) ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .inFirst(inFirst), .inLast(inLast), .outReady(outReady), .fill(fill),
    .inReady(inReady), .outLast(outLast), .strobe(strobe)
  );

  packer_dp #(.ACC_W(ACC_W), .FILL_W(FILL_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .fill(fill),
    .outValid(outValid), .outData(outData)
  );

  packer_len #(.LEN_W(LEN_W)) len_i (
    .lenN(lenN), .lenBytes(lenBytes)
  );
endmodule

// File: tb/ninebit_frame_packer_tb_top.sv
`timescale 1ns/1ps
module ninebit_frame_packer_tb_top;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [7:0]       inData = '0;
  logic             inFirst = 1'b0;
  logic             inLast = 1'b0;
  logic             outValid;
  logic             outReady = 1'b0;
  logic [7:0]       outData;
  logic             outLast;
  logic [LEN_W-1:0] lenN = '0;
  logic [LEN_W+3:0] lenBytes;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  bit    holdOut = 1'b0;
  bit    done = 1'b0;
  logic [7:0] expData[$];
  bit         expLast[$];
  string      expTag[$];

  always #5 clk = ~clk;

  ninebit_frame_packer #(.LEN_W(LEN_W), .ACC_W(16)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inFirst(inFirst), .inLast(inLast),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .lenN(lenN), .lenBytes(lenBytes)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] dataByte(input logic [7:0] cmd, input int i);
    return cmd ^ 8'(i * 29 + 3);
  endfunction

  // drive one byte; called just after a falling edge
  task automatic pushByte(input logic [7:0] d, input logic f, input logic l);
    inValid = 1'b1; inData = d; inFirst = f; inLast = l;
    #1;
    while (!inReady) begin @(negedge clk); #1; end
    @(negedge clk);
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
    if (l) begin
      #1;
      check(inReady == 1'b0, "R8 inReady after last", int'(inReady), 0);
    end
  endtask

  // scoreboard producer: build the expected bit stream, then drive the frame
  task automatic sendFrame(input logic [7:0] cmd, input int n, input logic firstMark);
    bit bits[$];
    int nbytes;
    int realBytes;
    logic [7:0] d;
    bits.push_back(1'b0);
    for (int b = 7; b >= 0; b--) bits.push_back(cmd[b]);
    for (int i = 0; i < n; i++) begin
      d = dataByte(cmd, i);
      bits.push_back(1'b1);
      for (int b = 7; b >= 0; b--) bits.push_back(d[b]);
    end
    realBytes = (bits.size() + 7) / 8;
    while (bits.size() % 72 != 0) bits.push_back(1'b0);
    nbytes = bits.size() / 8;
    check(nbytes == ((n + 8) / 8) * 9, "R4 frame byte count", nbytes, ((n + 8) / 8) * 9);
    lenN = LEN_W'(n);
    #1;
    check(int'(lenBytes) == nbytes, "R6 lenBytes for frame", int'(lenBytes), nbytes);
    for (int j = 0; j < nbytes; j++) begin
      for (int b = 0; b < 8; b++) d[7-b] = bits[j*8+b];
      expData.push_back(d);
      expLast.push_back(j == nbytes - 1);
      if (j < 2) expTag.push_back(firstMark ? "R2 R1 head" : "R7 R2 head");
      else if (j >= realBytes) expTag.push_back("R4 zero pad");
      else expTag.push_back("R3 R1 packing");
    end
    pushByte(cmd, firstMark, n == 0);
    for (int i = 0; i < n; i++) pushByte(dataByte(cmd, i), 1'b0, i == n - 1);
  endtask

  // scoreboard consumer: throttles outReady and compares each transferred byte
  initial begin
    logic [7:0] heldData;
    bit         heldPending;
    heldPending = 1'b0;
    heldData = '0;
    forever begin
      @(negedge clk);
      cyc++;
      outReady = holdOut ? 1'b0 : ((cyc % 7) != 2 && (cyc % 11) != 5);
      #1;
      if (!rst) begin
        if (heldPending) begin
          check(outValid == 1'b1, "R9 valid held", int'(outValid), 1);
          check(outData == heldData, "R9 data held", int'(outData), int'(heldData));
        end
        heldPending = outValid && !outReady;
        heldData = outData;
        if (outValid && outReady) begin
          if (expData.size() == 0) begin
            check(1'b0, "R4 unexpected output byte", int'(outData), 0);
          end else begin
            string t;
            logic [7:0] e;
            bit el;
            e = expData.pop_front();
            el = expLast.pop_front();
            t = expTag.pop_front();
            check(outData == e, t, int'(outData), int'(e));
            check(outLast == el, "R5 outLast", int'(outLast), int'(el));
          end
        end
      end else begin
        heldPending = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R4 act=%0d exp=0 pending bytes", expData.size());
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drain();
    while (expData.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(outValid == 1'b0, "R10 reset outValid", int'(outValid), 0);
    check(inReady == 1'b1, "R10 reset inReady", int'(inReady), 1);

    // size query at the boundaries of a 72-bit group
    begin
      int ns[6] = '{0, 6, 7, 8, 15, 100};
      foreach (ns[k]) begin
        lenN = LEN_W'(ns[k]);
        #1;
        check(int'(lenBytes) == ((ns[k] + 8) / 8) * 9, "R6 lenBytes",
              int'(lenBytes), ((ns[k] + 8) / 8) * 9);
      end
    end
    @(negedge clk);

    sendFrame(8'hA5, 0, 1'b1);   // command only: 0x52 0x80 then zeros
    sendFrame(8'h2C, 7, 1'b1);   // eight words, exact group, no padding
    sendFrame(8'h3A, 8, 1'b1);   // nine words, second group mostly padding
    sendFrame(8'h77, 20, 1'b1);
    sendFrame(8'h5E, 3, 1'b0);   // no start mark, no frame open: still a command
    drain();

    // reset with a frame open and output stalled
    holdOut = 1'b1;
    pushByte(8'hF0, 1'b1, 1'b0);
    @(negedge clk); #1;
    check(outValid == 1'b1, "R3 byte ready from 9 held bits", int'(outValid), 1);
    check(inReady == 1'b0, "R11 stall while full", int'(inReady), 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(outValid == 1'b0, "R10 mid-frame reset outValid", int'(outValid), 0);
    check(inReady == 1'b1, "R10 mid-frame reset inReady", int'(inReady), 1);
    holdOut = 1'b0;
    @(negedge clk);
    sendFrame(8'h96, 2, 1'b0);   // R10: first byte after reset is a command
    sendFrame(8'hC3, 15, 1'b1);
    drain();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule